// File: doc/BRIEF.md
# Message Descriptor Register Queue

This block sits between user software and an outbound DMA engine. Software builds an outgoing message by writing descriptor words one at a time into a circular store of 64 entries. The words it writes are staged: the consumer cannot see them. A single launch strobe then commits every staged word of that message at once. The DMA engine pulls committed descriptors, oldest first, through a valid/ready pop port.

The store keeps three pointers: a read head, a committed tail and a staging tail. A message may hold at most 16 descriptors. Several readable values guide software. A space figure gives the largest number of descriptors that can still be written. A save length gives the staged count of the open message, so an operating system can record it on a context switch. Two sticky error flags record an illegal length and a write attempted into a full store. A clear strobe resets both flags.

Top module: `msgDescQueue`

## Requirements
- R1: After reset, popValid is 0, saveLen is 0, spaceAvail is 16 and both error flags are 0.
- R2: A write with spaceAvail non-zero stores wrData and raises saveLen by one on the next cycle. Staged words never make popValid rise before a launch.
- R3: A launch with saveLen non-zero makes all staged words visible together on the next cycle and clears saveLen. popData then presents them in write order, and popValid stays high until the last one is taken.
- R4: A write in the same cycle as a successful launch is not part of the launched message. It becomes the first word of the next message, so saveLen reads 1 afterwards.
- R5: spaceAvail equals the smaller of (64 minus the words written and not yet popped) and (16 minus saveLen).
- R6: A write while the store holds 64 words is ignored: no pointer or count changes. errOverflow is set on the next cycle.
- R7: A write while saveLen is 16 and no launch is asserted is ignored, and errLength is set on the next cycle.
- R8: A launch with saveLen equal to 0 commits nothing and sets errLength on the next cycle.
- R9: popReq with popValid low has no effect. popReq with popValid high removes exactly one word.
- R10: clearErr clears both error flags on the next cycle. A new error in the same cycle wins over the clear.
- R11: Words keep their order and values when the pointers wrap past the end of the 64-entry store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one descriptor word into the open message |
| wrData | input | 32 | Descriptor word |
| launch | input | 1 | Commit the open message |
| clearErr | input | 1 | Clear both error flags |
| popReq | input | 1 | Consumer takes the word on popData |
| popValid | output | 1 | A committed word is available |
| popData | output | 32 | Oldest committed word |
| spaceAvail | output | 5 | Largest number of words writable now |
| saveLen | output | 5 | Staged words of the open message |
| errLength | output | 1 | Sticky illegal-length flag |
| errOverflow | output | 1 | Sticky write-into-full flag |

## Verification
The bench targets the cases where the atomic commit can leak or lose words.

- It writes in the same cycle as a launch. A design that folds that word into the launched message shows saveLen 0 and one extra popped word.
- It fills the store to exactly 64 words and then writes again. A design that accepts the extra word overwrites the oldest unread entry.
- It writes a 17th word and launches an empty message. A design that misses either case leaves errLength clear or commits a bogus entry.
- Long random runs wrap the pointers many times while pops and clears overlap errors. Misordered data, or a clear that beats a fresh error, shows up as a value mismatch.

// File: rtl/msgDescPkg.sv
package msgDescPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrStb;   // store wrData at wrIdx
    logic popStb;  // entry at rdIdx is consumed this cycle
  } dpStrobe_t;
endpackage

// File: rtl/msgDescCtrl.sv
module msgDescCtrl
  import msgDescPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int MAX_PER_MSG = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = $clog2(MAX_PER_MSG + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          launch,
  input  logic          clearErr,
  input  logic          popReq,
  output dpStrobe_t     strobes,
  output logic [AW-1:0] wrIdx,
  output logic [AW-1:0] rdIdx,
  output logic          popValid,
  output logic [CW-1:0] spaceAvail,
  output logic [CW-1:0] saveLen,
  output logic          errLength,
  output logic          errOverflow
);
  logic [PW-1:0] head, commitTail, stageTail;
  logic [CW-1:0] stagedCnt;
  logic [PW-1:0] used, free;
  logic [CW-1:0] stageRoom;
  logic launchOk, launchBad, wrAccept, wrFull, wrTooLong, popFire;

  always_comb begin
    used      = stageTail - head;
    free      = PW'(DEPTH) - used;
    stageRoom = CW'(MAX_PER_MSG) - stagedCnt;
    launchOk  = launch && (stagedCnt != '0);
    launchBad = launch && (stagedCnt == '0);
    wrFull    = wrEn && (free == '0);
    wrTooLong = wrEn && !wrFull && !launchOk && (stagedCnt == CW'(MAX_PER_MSG));
    wrAccept  = wrEn && !wrFull && !wrTooLong;
    popValid  = (head != commitTail);
    popFire   = popReq && popValid;
    spaceAvail = (free < PW'(stageRoom)) ? CW'(free) : stageRoom;
    saveLen   = stagedCnt;
    wrIdx     = stageTail[AW-1:0];
    rdIdx     = head[AW-1:0];
    strobes.wrStb  = wrAccept;
    strobes.popStb = popFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head <= '0; commitTail <= '0; stageTail <= '0; stagedCnt <= '0;
      errLength <= 1'b0; errOverflow <= 1'b0;
    end else begin
      if (popFire) head <= head + 1'b1;
      if (wrAccept) stageTail <= stageTail + 1'b1;
      if (launchOk) begin
        commitTail <= stageTail;
        stagedCnt  <= CW'(wrAccept);
      end else if (wrAccept) begin
        stagedCnt <= stagedCnt + 1'b1;
      end
      if (launchBad || wrTooLong) errLength <= 1'b1;
      else if (clearErr)          errLength <= 1'b0;
      if (wrFull)                 errOverflow <= 1'b1;
      else if (clearErr)          errOverflow <= 1'b0;
    end
  end

  // R7
  stage_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stagedCnt <= CW'(MAX_PER_MSG));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    used <= PW'(DEPTH));
  // R6
  full_write_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && free == '0) |=> (errOverflow && $stable(stageTail)));
  // R8
  empty_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (launch && stagedCnt == '0) |=> (errLength && $stable(commitTail)));
  // R9
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !popValid) |=> $stable(head));
  // R2
  staged_hidden_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!launch) |=> $stable(commitTail));
endmodule

// File: rtl/msgDescData.sv
module msgDescData
  import msgDescPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [AW-1:0]     wrIdx,
  input  logic [AW-1:0]     rdIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] popData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrStb) store[wrIdx] <= wrData;
  end

  assign popData = store[rdIdx];

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStb |=> (store[$past(wrIdx)] == $past(wrData)));
  // R11
  no_clobber_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.popStb |-> !(strobes.wrStb && wrIdx == rdIdx));
endmodule

// File: rtl/msgDescQueue.sv
module msgDescQueue
  import msgDescPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int MAX_PER_MSG = 16,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(MAX_PER_MSG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              launch,
  input  logic              clearErr,
  input  logic              popReq,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  output logic [CW-1:0]     spaceAvail,
  output logic [CW-1:0]     saveLen,
  output logic              errLength,
  output logic              errOverflow
);
  dpStrobe_t     strobes;
  logic [AW-1:0] wrIdx, rdIdx;

  msgDescCtrl #(.DEPTH(DEPTH), .MAX_PER_MSG(MAX_PER_MSG)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .launch(launch), .clearErr(clearErr),
    .popReq(popReq), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .popValid(popValid), .spaceAvail(spaceAvail), .saveLen(saveLen),
    .errLength(errLength), .errOverflow(errOverflow));

  msgDescData #(.DEPTH(DEPTH), .DATA_W(DATA_W)) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrData(wrData), .popData(popData));
endmodule

// File: tb/msgDescQueue_test.sv
module msgDescQueue_test;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, launch = 0, clearErr = 0, popReq = 0;
  logic [31:0] wrData = '0;
  logic popValid, errLength, errOverflow;
  logic [31:0] popData;
  logic [4:0] spaceAvail, saveLen;
  int errors = 0, checks = 0;
  string phaseTag = "R1";
  logic [31:0] committedQ[$];
  logic [31:0] stagedQ[$];
  bit mErrL = 0, mErrO = 0;

  always #(PERIOD/2) clk = ~clk;

  msgDescQueue uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .launch(launch), .clearErr(clearErr), .popReq(popReq), .popValid(popValid),
    .popData(popData), .spaceAvail(spaceAvail), .saveLen(saveLen),
    .errLength(errLength), .errOverflow(errOverflow));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s): actual=%0d expected=%0d", tag, phaseTag, act, exp);
    end
  endtask

  function automatic int expSpace();
    int fr = 64 - committedQ.size() - stagedQ.size();
    int rm = 16 - stagedQ.size();
    return (fr < rm) ? fr : rm;
  endfunction

  // compare every output against the model
  task automatic checkAll();
    chk("R3 popValid", int'(popValid), int'(committedQ.size() > 0));
    if (committedQ.size() > 0) chk("R11 popData", int'(popData), int'(committedQ[0]));
    chk("R5 spaceAvail", int'(spaceAvail), expSpace());
    chk("R2 saveLen", int'(saveLen), stagedQ.size());
    chk("R7 errLength", int'(errLength), int'(mErrL));
    chk("R6 errOverflow", int'(errOverflow), int'(mErrO));
  endtask

  // drive one cycle at negedge, check pre-edge outputs, update model
  task automatic step(bit w, logic [31:0] d, bit l, bit p, bit c);
    int fr = 64 - committedQ.size() - stagedQ.size();
    int stg = stagedQ.size();
    bit lOk, lBad, wFull, wLong, wAcc;
    wrEn = w; wrData = d; launch = l; popReq = p; clearErr = c;
    #1;
    checkAll();
    lOk = l && stg > 0; lBad = l && stg == 0;
    wFull = w && fr == 0;
    wLong = w && !wFull && !lOk && stg == 16;
    wAcc = w && !wFull && !wLong;
    if (p && committedQ.size() > 0) void'(committedQ.pop_front());
    if (lOk) begin
      foreach (stagedQ[i]) committedQ.push_back(stagedQ[i]);
      stagedQ.delete();
    end
    if (wAcc) stagedQ.push_back(d);
    if (lBad || wLong) mErrL = 1; else if (c) mErrL = 0;
    if (wFull) mErrO = 1; else if (c) mErrO = 0;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed = 32'h1d5c;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    #1; checkAll();
    @(negedge clk);
    // R2 staged words stay hidden
    phaseTag = "R2";
    for (int i = 0; i < 3; i++) step(1, 32'hA0 + i, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    // R3 launch commits atomically
    phaseTag = "R3";
    step(0, 0, 1, 0, 0);
    // R4 write with launch starts next message
    phaseTag = "R4";
    step(1, 32'hB0, 0, 0, 0);
    step(1, 32'hB1, 1, 0, 0);
    chk("R4 saveLen after write+launch", int'(saveLen), 1);
    step(0, 0, 1, 0, 0);
    // R9 drain then pop empty
    phaseTag = "R9";
    while (committedQ.size() > 0) step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    // R8 empty launch
    phaseTag = "R8";
    step(0, 0, 1, 0, 0);
    chk("R8 errLength", int'(errLength), 1);
    // R10 clear, then clear with concurrent error
    phaseTag = "R10";
    step(0, 0, 0, 0, 1);
    chk("R10 cleared", int'(errLength), 0);
    step(0, 0, 1, 0, 1);
    chk("R10 error wins", int'(errLength), 1);
    step(0, 0, 0, 0, 1);
    // R7 seventeenth word
    phaseTag = "R7";
    for (int i = 0; i < 17; i++) step(1, 32'hC00 + i, 0, 0, 0);
    chk("R7 saveLen capped", int'(saveLen), 16);
    step(0, 0, 1, 0, 1);
    // R6 fill the store to 64 then overflow
    phaseTag = "R6";
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < 16; i++) step(1, 32'hD000 + m * 16 + i, 0, 0, 0);
      step(0, 0, 1, 0, 0);
    end
    chk("R6 spaceAvail full", int'(spaceAvail), 0);
    step(1, 32'hDEAD, 0, 0, 0);
    chk("R6 errOverflow", int'(errOverflow), 1);
    step(0, 0, 0, 1, 1);
    // R11 random traffic with wrap
    phaseTag = "R11";
    for (int n = 0; n < 6000; n++)
      step($urandom_range(99) < 55, $urandom, $urandom_range(99) < 12,
           $urandom_range(99) < 45, $urandom_range(99) < 4);
    while (stagedQ.size() > 0 || committedQ.size() > 0) step(0, 0, 1, 1, 0);
    #1; checkAll();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule